// File: doc/BRIEF.md
# Reloadable Bit-Rate Timer

This block is the timing source for a serial bit clock. A down counter runs once per clock while the run input is high. When the count has reached zero, the block gives a single-cycle tick and loads the counter again from a reload register. A reload value of N therefore gives one tick every N+1 cycles.

Software reaches the timer through one register address that has two meanings. A write stores a new reload value and asks for an immediate timer load. A read shows the live count, not the stored reload value. If a write arrives while the timer is stopped, the counter keeps its value. A pending flag records the load, and the load happens at the first clock edge that sees run high. If several writes arrive while stopped, only the last value is used.

The register port is a plain single-cycle strobe with no back-pressure. A write is accepted in the cycle where it is asserted, and the read data is valid in every cycle. Run and tick are plain control and status pins.

Top module: `brt_timer`

## Requirements
- R1: After reset the count reads 0 and tick is low. The reload register and the pending flag are also cleared.
- R2: rd_data always shows the live counter value. After a load followed by one decrement it differs from the stored reload value.
- R3: A write while run is high sets the count to wr_data at that edge, so rd_data equals wr_data in the following cycle.
- R4: While run is high and no load is due, a nonzero count goes down by exactly one per clock.
- R5: When run is high, no load is due and the count is 0, the next edge loads the reload value and raises tick for that one following cycle. A reload value of N gives a tick period of N+1 cycles. A reload value of 0 gives a tick in every cycle.
- R6: While run is low, the count holds its value and tick stays low.
- R7: A write while run is low leaves the count unchanged and sets a pending flag. At the first edge with run high, the count is loaded with the most recent value written.
- R8: When a write and an expiry (count 0, run high) meet at the same edge, the write wins. The count takes wr_data and no tick is produced.
- R9: When a load is pending and a new write arrives at the same edge where run is first high, the count takes that new wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Count enable; also releases a pending load |
| wr_en | input | 1 | Single-cycle write strobe for the reload register |
| wr_data | input | W | New reload value |
| rd_data | output | W | Live counter value |
| tick | output | 1 | One-cycle pulse following each expiry |

## Verification
Two functions can meet in one cycle: a register write and a counter expiry. The bench sets a small reload value and counts down to zero. It then puts the write strobe in exactly the cycle where the read data shows 0, and judges the result by rd_data taking the written value and tick staying low. A second meeting is tested the same way: the release of a pending load and a fresh write on the first run-high edge. This case is judged by the fresh value winning over the older pending one.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int unsigned CNT_W = 16;
endpackage

// File: rtl/brt_reload_reg.sv
module brt_reload_reg #(
  parameter int unsigned W = brt_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] reload_q,
  output logic         load_now,
  output logic [W-1:0] load_val,
  output logic         pending_q
);
  // A write made while stopped is remembered until run is seen high
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (wr_en) reload_q <= wr_data;
      if (run)        pending_q <= 1'b0;
      else if (wr_en) pending_q <= 1'b1;
    end
  end

  assign load_now = run && (wr_en || pending_q);
  assign load_val = wr_en ? wr_data : reload_q;

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_en) |=> pending_q);
  // R7
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> !pending_q);
endmodule

// File: rtl/brt_counter.sv
module brt_counter #(
  parameter int unsigned W = brt_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load_now,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_q,
  output logic         expire
);
  assign expire = run && !load_now && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 count_q <= '0;
    else if (load_now || expire) count_q <= load_val;
    else if (run)               count_q <= count_q - 1'b1;
  end

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_now && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
  // R6
  hold_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count_q));
endmodule

// File: rtl/brt_tick_gen.sv
module brt_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic tick_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= expire;
  end
endmodule

// File: rtl/brt_timer.sv
module brt_timer #(
  parameter int unsigned W = brt_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         tick
);
  logic [W-1:0] reload_q, load_val, count_q;
  logic         load_now, pending_q, expire;

  brt_reload_reg #(.W(W)) u_rld (
    .clk, .rst_n, .run, .wr_en, .wr_data,
    .reload_q, .load_now, .load_val, .pending_q
  );

  brt_counter #(.W(W)) u_cnt (
    .clk, .rst_n, .run, .load_now, .load_val, .count_q, .expire
  );

  brt_tick_gen u_tick (
    .clk, .rst_n, .expire, .tick_q(tick)
  );

  assign rd_data = count_q;

  // R3
  run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en) |=> rd_data == $past(wr_data));
  // R5
  tick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> rd_data == reload_q);
  // R6
  no_tick_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
  // R8
  write_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tick);
endmodule

// File: tb/sim_brt_timer.sv
`timescale 1ns/1ps
module sim_brt_timer;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic tick;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brt_timer #(.W(W)) u0 (.clk, .rst_n, .run, .wr_en, .wr_data, .rd_data, .tick);

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int v);
    wr_en = 1'b1; wr_data = W'(v);
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", int'(rd_data), 0);
    check("R1 tick", int'(tick), 0);
  endtask

  task automatic t_stopped_write();
    run = 1'b0;
    wr(10);
    check("R7 count held", int'(rd_data), 0);
    wr(7);
    step(); step();
    check("R6 held", int'(rd_data), 0);
    check("R6 tick", int'(tick), 0);
    run = 1'b1;
    step();
    check("R7 deferred load", int'(rd_data), 7);
  endtask

  task automatic t_countdown();
    for (int k = 6; k >= 0; k--) begin
      step();
      check("R4 decrement", int'(rd_data), k);
      check("R4 no tick", int'(tick), 0);
    end
    step();
    check("R5 tick", int'(tick), 1);
    check("R5 reload", int'(rd_data), 7);
    step();
    check("R5 one cycle", int'(tick), 0);
    check("R2 live not reload", int'(rd_data == 16'd7), 0);
  endtask

  task automatic t_stop_mid();
    logic [W-1:0] snap;
    run = 1'b0;
    step();
    snap = rd_data;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R6 stable", int'(rd_data), int'(snap));
      check("R6 tick low", int'(tick), 0);
    end
    run = 1'b1;
  endtask

  task automatic t_run_write();
    wr(3);
    check("R3 immediate", int'(rd_data), 3);
    check("R3 no tick", int'(tick), 0);
  endtask

  task automatic t_collision();
    wr(2);
    step();
    check("R8 setup", int'(rd_data), 1);
    step();
    check("R8 setup zero", int'(rd_data), 0);
    wr(9);
    check("R8 write wins", int'(rd_data), 9);
    check("R8 no tick", int'(tick), 0);
  endtask

  task automatic t_release_write();
    run = 1'b0;
    wr(5);
    run = 1'b1;
    wr(12);
    check("R9 fresh value", int'(rd_data), 12);
    step();
    check("R9 counts on", int'(rd_data), 11);
  endtask

  task automatic t_zero_reload();
    wr(0);
    check("R5 zero load", int'(rd_data), 0);
    check("R5 zero no tick", int'(tick), 0);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R5 every cycle", int'(tick), 1);
      check("R5 zero count", int'(rd_data), 0);
    end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_stopped_write();
    t_countdown();
    t_stop_mid();
    t_run_write();
    t_collision();
    t_release_write();
    t_zero_reload();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule